// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a multi-channel event timer. It holds one channel's 64-bit control and capability word, its comparator and its period. It watches the shared free-running main counter and emits a one-cycle event pulse toward the interrupt logic when the counter reaches the comparator. Address decoding and interrupt delivery belong to neighbouring blocks. This block receives decoded write strobes and exposes its registers as plain read buses.

The channel runs in one of two modes. In one-shot mode the comparator stays where software put it, so a second event needs the counter to wrap all the way round. In periodic mode a comparator write normally sets only the period. The comparator itself is loaded only while a self-clearing "load comparator" bit is armed. On every match the comparator moves forward by the period. If the counter has run past the comparator (after the counter was rewritten, for example), the channel fires once and jumps the comparator to the first period boundary ahead of the counter.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the control word reads {ROUTE_CAP, 32'h0000_8010} (periodic-capable bit 4 and message-capable bit 15 set), the comparator reads 32'hFFFF_FFFF, the period reads 0 and the event output is low.
- R2: A control write replaces only the bits selected by the write mask. Bits 63:32 (route capability), bit 15 (message-capable), bit 5 (size, reads 0) and bit 4 (periodic-capable) keep their values, and bit 8 (32-bit mode) always reads 0.
- R3: The channel is active when bit 2 (interrupt enable) or bit 3 (periodic type) is set. An inactive channel produces no event even when the counter equals the comparator.
- R4: In one-shot mode (bit 3 clear), a comparator write loads the comparator and forces the period to 0.
- R5: In periodic mode, a comparator write loads the period. It loads the comparator too only if bit 6 (load comparator) is set. Bit 6 reads 0 after any comparator write.
- R6: A control write that clears bit 3 while it was set forces the period to 0.
- R7: The event output pulses high for one cycle, in the cycle after a counter tick at which the main counter is enabled, the channel is active and the counter equals the comparator. There is no event without a tick or with the main counter disabled.
- R8: In periodic mode each match advances the comparator by the period, modulo 2^32. With period 0 the comparator stays put.
- R9: In one-shot mode a match leaves the comparator unchanged, so the next event comes only when the counter again reaches the same value.
- R10: In periodic mode with a nonzero period, a tick at which the counter leads the comparator by a lag L with 0 < L < 2^31 produces an event. It sets the comparator to comparator + (L / period + 1) * period.
- R11: A comparator write in the same cycle as a matching tick takes effect instead of the periodic advance. The event still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Main counter enabled |
| cnt_tick | input | 1 | Main counter took a new value this cycle |
| cnt_val | input | CW | Shared main counter value |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 64 | Control word write data |
| cfg_wmask | input | 64 | Per-bit write enable for the control word |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | CW | Comparator write data |
| cfg_rd | output | 64 | Control and capability word |
| cmp_rd | output | CW | Current comparator |
| period_rd | output | CW | Current period |
| evt | output | 1 | One-cycle match event |

## Verification
The hardest state to reach from the ports is a periodic channel whose comparator has fallen behind the counter. In normal stepping the periodic advance never lets that happen. The bench gets there by driving the counter input with a jump: a tick whose value lies several periods past the comparator. It then checks that the comparator lands on the next boundary and not just one period ahead. Two other cases get their own vectors: the comparator advance wrapping across 2^32, and a comparator write that collides with a matching tick.

// File: rtl/cmpch_pkg.sv
`timescale 1ns/1ps
package cmpch_pkg;
  // control word bit positions
  localparam int unsigned B_ITYPE   = 1;
  localparam int unsigned B_IEN     = 2;
  localparam int unsigned B_PERIOD  = 3;
  localparam int unsigned B_PCAP    = 4;
  localparam int unsigned B_SIZE    = 5;
  localparam int unsigned B_LOADCMP = 6;
  localparam int unsigned B_M32     = 8;
  localparam int unsigned B_MEN     = 14;
  localparam int unsigned B_MCAP    = 15;

  // low-half capability bits that are hardwired
  localparam logic [31:0] LO_RO_MASK  = (32'd1 << B_MCAP) | (32'd1 << B_SIZE) | (32'd1 << B_PCAP);
  localparam logic [31:0] LO_ZERO     = (32'd1 << B_M32);
  localparam logic [31:0] LO_RESET    = (32'd1 << B_MCAP) | (32'd1 << B_PCAP);
  localparam logic [63:0] RO_MASK     = {32'hFFFF_FFFF, LO_RO_MASK};
  localparam logic [63:0] FORCE0_MASK = {32'h0, LO_ZERO};
endpackage

// File: rtl/cmpch_cfg_reg.sv
`timescale 1ns/1ps
module cmpch_cfg_reg
  import cmpch_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [63:0] cfg_wdata,
  input  logic [63:0] cfg_wmask,
  input  logic        cmp_we,
  output logic [63:0] cfg_q,
  output logic        leave_periodic
);
  localparam logic [63:0] CFG_RESET = {ROUTE_CAP, LO_RESET};

  // apply mask, then restore hardwired bits
  function automatic logic [63:0] merge_cfg(input logic [63:0] cur,
                                            input logic [63:0] wd,
                                            input logic [63:0] wm);
    logic [63:0] t;
    t = (cur & ~wm) | (wd & wm);
    t = (t & ~(RO_MASK | FORCE0_MASK)) | (cur & RO_MASK);
    return t;
  endfunction

  logic [63:0] cfg_d;
  logic [63:0] merged;

  always_comb begin
    merged         = merge_cfg(cfg_q, cfg_wdata, cfg_wmask);
    cfg_d          = cfg_we ? merged : cfg_q;
    leave_periodic = cfg_we & cfg_q[B_PERIOD] & ~merged[B_PERIOD];
    if (cmp_we) cfg_d[B_LOADCMP] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cmpch_match.sv
`timescale 1ns/1ps
module cmpch_match #(
  parameter int unsigned CW = 32
) (
  input  logic          cnt_en,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_q,
  input  logic [CW-1:0] per_q,
  input  logic          active,
  input  logic          periodic,
  output logic          hit_exact,
  output logic          hit_late,
  output logic [CW-1:0] cmp_next
);
  // first period boundary strictly ahead of the counter
  function automatic logic [CW-1:0] catch_up(input logic [CW-1:0] c,
                                             input logic [CW-1:0] lag,
                                             input logic [CW-1:0] p);
    logic [CW-1:0] steps;
    if (p == '0) return c;
    steps = lag / p + 1'b1;
    return c + steps * p;
  endfunction

  logic [CW-1:0] lag;
  logic          gate;

  always_comb begin
    lag       = cnt_val - cmp_q;
    gate      = cnt_en & cnt_tick & active;
    hit_exact = gate & (lag == '0);
    hit_late  = gate & periodic & (per_q != '0) & (lag != '0) & ~lag[CW-1];
    cmp_next  = catch_up(cmp_q, lag, per_q);
  end
endmodule

// File: rtl/cmpch_cmp_reg.sv
`timescale 1ns/1ps
module cmpch_cmp_reg #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          periodic,
  input  logic          load_cmp,
  input  logic          leave_periodic,
  input  logic          fire,
  input  logic [CW-1:0] cmp_next,
  output logic [CW-1:0] cmp_q,
  output logic [CW-1:0] per_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      if (cmp_we) begin
        if (periodic) begin
          per_q <= cmp_wdata;
          if (load_cmp) cmp_q <= cmp_wdata;
        end else begin
          cmp_q <= cmp_wdata;
          per_q <= '0;
        end
      end else if (fire && periodic) begin
        cmp_q <= cmp_next;
      end
      if (leave_periodic) per_q <= '0;
    end
  end
endmodule

// File: rtl/evt_cmp_channel.sv
`timescale 1ns/1ps
module evt_cmp_channel
  import cmpch_pkg::*;
#(
  parameter int unsigned CW        = 32,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cnt_val,
  input  logic          cfg_we,
  input  logic [63:0]   cfg_wdata,
  input  logic [63:0]   cfg_wmask,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  output logic [63:0]   cfg_rd,
  output logic [CW-1:0] cmp_rd,
  output logic [CW-1:0] period_rd,
  output logic          evt
);
  logic          leave_periodic;
  logic          tmr_active;
  logic          hit_exact;
  logic          hit_late;
  logic          fire;
  logic [CW-1:0] cmp_next;

  cmpch_cfg_reg #(.ROUTE_CAP(ROUTE_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_wmask(cfg_wmask), .cmp_we(cmp_we), .cfg_q(cfg_rd),
    .leave_periodic(leave_periodic)
  );

  assign tmr_active = cfg_rd[B_IEN] | cfg_rd[B_PERIOD];

  cmpch_match #(.CW(CW)) u_match (
    .cnt_en(cnt_en), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cmp_q(cmp_rd), .per_q(period_rd), .active(tmr_active),
    .periodic(cfg_rd[B_PERIOD]), .hit_exact(hit_exact),
    .hit_late(hit_late), .cmp_next(cmp_next)
  );

  assign fire = hit_exact | hit_late;

  cmpch_cmp_reg #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .periodic(cfg_rd[B_PERIOD]), .load_cmp(cfg_rd[B_LOADCMP]),
    .leave_periodic(leave_periodic), .fire(fire), .cmp_next(cmp_next),
    .cmp_q(cmp_rd), .per_q(period_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= fire;
  end
endmodule

// File: rtl/cmpch_chk.sv
`timescale 1ns/1ps
module cmpch_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          cnt_tick,
  input logic          cmp_we,
  input logic [63:0]   cfg_rd,
  input logic [CW-1:0] cmp_rd,
  input logic [CW-1:0] period_rd,
  input logic          evt,
  input logic          hit_exact,
  input logic          hit_late
);
  p_evt_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(cnt_tick && cnt_en));

  p_evt_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> ($past(cfg_rd[2]) || $past(cfg_rd[3])));

  p_cap_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg_rd[63:32]));

  p_hardwired_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd[15] && cfg_rd[4] && !cfg_rd[5] && !cfg_rd[8]);

  p_oneshot_period_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[3] |-> (period_rd == '0));

  p_loadcmp_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> !cfg_rd[6]);

  p_oneshot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd[3] && !cmp_we) |=> $stable(cmp_rd));

  p_periodic_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_exact && cfg_rd[3] && !cmp_we) |=> (cmp_rd == $past(cmp_rd) + $past(period_rd)));

  p_late_fires_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_late |=> evt);
endmodule

bind evt_cmp_channel cmpch_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_tick(cnt_tick),
  .cmp_we(cmp_we), .cfg_rd(cfg_rd), .cmp_rd(cmp_rd), .period_rd(period_rd),
  .evt(evt), .hit_exact(hit_exact), .hit_late(hit_late)
);

// File: tb/evt_cmp_channel_tb.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb;
  localparam int unsigned CW = 32;

  typedef struct packed {
    logic [2:0]  op;     // 0 cfg wr, 1 cmp wr, 2 tick, 3 tick+cmp wr, 4 idle
    logic [31:0] d;
    logic [31:0] cnt;
    logic [31:0] e_cfg;  // low half of control word
    logic [31:0] e_cmp;
    logic [31:0] e_per;
    logic        e_evt;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h4,        32'h0,        32'h8014, 32'hFFFF_FFFF, 32'h0,  1'b0, 4'd2},  // R2
    '{3'd1, 32'h100,      32'h0,        32'h8014, 32'h100, 32'h0,   1'b0, 4'd4},       // R4
    '{3'd2, 32'h0,        32'hFF,       32'h8014, 32'h100, 32'h0,   1'b0, 4'd7},       // R7
    '{3'd2, 32'h0,        32'h100,      32'h8014, 32'h100, 32'h0,   1'b1, 4'd7},       // R7
    '{3'd2, 32'h0,        32'h101,      32'h8014, 32'h100, 32'h0,   1'b0, 4'd9},       // R9
    '{3'd0, 32'h16C,      32'h0,        32'h805C, 32'h100, 32'h0,   1'b0, 4'd2},       // R2
    '{3'd1, 32'h200,      32'h0,        32'h801C, 32'h200, 32'h200, 1'b0, 4'd5},       // R5
    '{3'd1, 32'h40,       32'h0,        32'h801C, 32'h200, 32'h40,  1'b0, 4'd5},       // R5
    '{3'd2, 32'h0,        32'h200,      32'h801C, 32'h240, 32'h40,  1'b1, 4'd8},       // R8
    '{3'd2, 32'h0,        32'h201,      32'h801C, 32'h240, 32'h40,  1'b0, 4'd8},       // R8
    '{3'd2, 32'h0,        32'h240,      32'h801C, 32'h280, 32'h40,  1'b1, 4'd8},       // R8
    '{3'd0, 32'h4,        32'h0,        32'h8014, 32'h280, 32'h0,   1'b0, 4'd6},       // R6
    '{3'd2, 32'h0,        32'h280,      32'h8014, 32'h280, 32'h0,   1'b1, 4'd9},       // R9
    '{3'd0, 32'h0,        32'h0,        32'h8010, 32'h280, 32'h0,   1'b0, 4'd3},       // R3
    '{3'd2, 32'h0,        32'h280,      32'h8010, 32'h280, 32'h0,   1'b0, 4'd3},       // R3
    '{3'd0, 32'h8,        32'h0,        32'h8018, 32'h280, 32'h0,   1'b0, 4'd3},       // R3
    '{3'd1, 32'h10,       32'h0,        32'h8018, 32'h280, 32'h10,  1'b0, 4'd5},       // R5
    '{3'd2, 32'h0,        32'h280,      32'h8018, 32'h290, 32'h10,  1'b1, 4'd3},       // R3
    '{3'd2, 32'h0,        32'h2B5,      32'h8018, 32'h2C0, 32'h10,  1'b1, 4'd10},      // R10
    '{3'd2, 32'h0,        32'h2C0,      32'h8018, 32'h2D0, 32'h10,  1'b1, 4'd10},      // R10
    '{3'd0, 32'h48,       32'h0,        32'h8058, 32'h2D0, 32'h10,  1'b0, 4'd5},       // R5
    '{3'd1, 32'hFFFF_FFF8, 32'h0,       32'h8018, 32'hFFFF_FFF8, 32'hFFFF_FFF8, 1'b0, 4'd5}, // R5
    '{3'd1, 32'h10,       32'h0,        32'h8018, 32'hFFFF_FFF8, 32'h10, 1'b0, 4'd5},  // R5
    '{3'd2, 32'h0,        32'hFFFF_FFF8, 32'h8018, 32'h8,  32'h10,  1'b1, 4'd8},       // R8 wrap
    '{3'd3, 32'h20,       32'h8,        32'h8018, 32'h8,   32'h20,  1'b1, 4'd11},      // R11
    '{3'd4, 32'h0,        32'h8,        32'h8018, 32'h8,   32'h20,  1'b0, 4'd7}        // R7 single pulse
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_en, cnt_tick;
  logic [CW-1:0] cnt_val;
  logic          cfg_we;
  logic [63:0]   cfg_wdata, cfg_wmask;
  logic          cmp_we;
  logic [CW-1:0] cmp_wdata;
  logic [63:0]   cfg_rd;
  logic [CW-1:0] cmp_rd, period_rd;
  logic          evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  evt_cmp_channel #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_tick(cnt_tick),
    .cnt_val(cnt_val), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_wmask(cfg_wmask), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .cfg_rd(cfg_rd), .cmp_rd(cmp_rd), .period_rd(period_rd), .evt(evt)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [63:0] e_cfg,
                           input logic [31:0] e_cmp, input logic [31:0] e_per,
                           input logic e_evt);
    check(req, "cfg", cfg_rd, e_cfg);
    check(req, "cmp", {32'h0, cmp_rd}, {32'h0, e_cmp});
    check(req, "period", {32'h0, period_rd}, {32'h0, e_per});
    check(req, "evt", {63'h0, evt}, {63'h0, e_evt});
  endtask

  // drive at negedge, one posedge, back to negedge with strobes released
  task automatic step(input logic [2:0] op, input logic [63:0] d,
                      input logic [63:0] m, input logic [31:0] cnt);
    cfg_we    = (op == 3'd0);
    cfg_wdata = d;
    cfg_wmask = m;
    cmp_we    = (op == 3'd1) || (op == 3'd3);
    cmp_wdata = d[31:0];
    cnt_tick  = (op == 3'd2) || (op == 3'd3);
    cnt_val   = cnt;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; cmp_we = 1'b0; cnt_tick = 1'b0;
  endtask

  localparam logic [63:0] LO_MASK = 64'h0000_0000_FFFF_FFFF;
  localparam logic [31:0] RCAP    = 32'h00F0_0000;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; cnt_tick = 1'b0; cnt_val = '0;
    cfg_we = 1'b0; cfg_wdata = '0; cfg_wmask = '0; cmp_we = 1'b0; cmp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_all("R1", {RCAP, 32'h8010}, 32'hFFFF_FFFF, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op, {32'h0, VEC[i].d}, LO_MASK, VEC[i].cnt);
      check_all($sformatf("R%0d vec%0d", VEC[i].req, i), {RCAP, VEC[i].e_cfg},
                VEC[i].e_cmp, VEC[i].e_per, VEC[i].e_evt);
    end

    // R7: matching value with main counter disabled -> no event
    cnt_en = 1'b0;
    step(3'd2, 64'h0, LO_MASK, 32'h8);
    check("R7", "evt cnt_en low", {63'h0, evt}, 64'h0);
    check("R7", "cmp cnt_en low", {32'h0, cmp_rd}, 64'h8);
    cnt_en = 1'b1;
    // R7: matching value without a tick -> no event
    step(3'd4, 64'h0, LO_MASK, 32'h8);
    check("R7", "evt no tick", {63'h0, evt}, 64'h0);

    // R2: full-width write of ones, hardwired bits keep/force
    step(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0);
    check("R2", "cfg all ones", cfg_rd, {RCAP, 32'hFFFF_FEDF});
    // R2: upper-half-only mask leaves the low half untouched
    step(3'd0, 64'h0, 64'hFFFF_FFFF_0000_0000, 32'h0);
    check("R2", "cfg upper mask", cfg_rd, {RCAP, 32'hFFFF_FEDF});
    check("R6", "period kept while periodic", {32'h0, period_rd}, 64'h20);
    // R6: clearing periodic type zeroes the period
    step(3'd0, 64'h0, LO_MASK, 32'h0);
    check("R6", "period after leave", {32'h0, period_rd}, 64'h0);
    check("R2", "cfg cleared", cfg_rd, {RCAP, 32'h8010});

    // R9: one-shot fires again only on the same counter value
    step(3'd0, 64'h4, LO_MASK, 32'h0);
    step(3'd1, 64'h30, LO_MASK, 32'h0);
    step(3'd2, 64'h0, LO_MASK, 32'h30);
    check("R9", "evt first", {63'h0, evt}, 64'h1);
    step(3'd2, 64'h0, LO_MASK, 32'h31);
    check("R9", "evt after", {63'h0, evt}, 64'h0);
    check("R9", "cmp held", {32'h0, cmp_rd}, 64'h30);
    step(3'd2, 64'h0, LO_MASK, 32'h30);
    check("R9", "evt after wrap", {63'h0, evt}, 64'h1);

    // R1: reset mid-run restores reset values
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1", {RCAP, 32'h8010}, 32'hFFFF_FFFF, 32'h0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule